// File: doc/BRIEF.md
# Arithmetic Shift Execution Unit

This unit performs the data-register arithmetic shifts of a classic 32-bit CISC instruction set. An issue stage presents a 16-bit shift opcode, the destination register value, the value of the register that may hold the count, and the current extend flag. The unit decodes the opcode, computes the shifted value with size-selective writeback, derives the five condition flags and the instruction's cycle cost, and then stays busy for exactly that many clock cycles before reporting the result.

Input side: the request is a valid/ready stream. `in_ready` is high only while the unit is idle. A request moves into the unit on a rising edge where both `in_valid` and `in_ready` are high. While the unit is busy or reporting, `in_valid` is ignored and the caller must hold or withdraw its request. Output side: the result is a one-cycle `out_valid` pulse with no back-pressure. The result, flag and cycle outputs keep their values until the next request is accepted.

Top module: `ashift_unit`

## Requirements
- R1: An opcode is legal only when bits [15:12] are 1110, bits [4:3] are 00 and the size field bits [7:6] is not 11. An illegal opcode gives `out_illegal`=1 and `out_valid` on the cycle after acceptance. In that case the destination comes back unchanged, N/Z/V/C read 0, X equals `in_x`, and the cycle cost is 0.
- R2: With bit 5 = 0, the count is bits [11:9]. The value 0 means a count of 8.
- R3: With bit 5 = 1, the count is `in_count_reg` modulo 64, that is, its low six bits.
- R4: Bit 8 = 0 selects a right shift. Vacated bits are filled with the sign bit of the selected size (bits [7:6]: 00 byte, 01 word, 10 long). A count at or above the width leaves every sized bit equal to the sign, and C equals the sign.
- R5: Bit 8 = 1 selects a left shift, which shifts in zeros. A count above the width gives a zero sized result and C = 0. A count equal to the width gives C = the operand's bit 0.
- R6: For byte and word sizes, bits of the destination above the size are returned unchanged.
- R7: For a nonzero count, C and X both equal the last bit shifted out. N is the sized result's top bit, and Z is set when the sized result is zero.
- R8: V is 0 for a right shift. For a left shift, V is 1 when the sized sign bit takes more than one value at any point during the shift.
- R9: For a zero count, N and Z describe the unchanged operand, V and C are 0, and X equals `in_x`.
- R10: The cycle cost is twice the count (after the modulo-64 step) plus 4 for long size, or plus 2 for byte and word sizes. `busy` is high for exactly that many cycles after acceptance, and `out_valid` is then high for one cycle.
- R11: `in_ready` is low while `busy` or `out_valid` is high, and `in_valid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to accept |
| in_opcode | input | 16 | Shift opcode |
| in_dst | input | 32 | Destination register value |
| in_count_reg | input | 32 | Value of the count register |
| in_x | input | 1 | Current extend flag |
| busy | output | 1 | Counting out the cycle cost |
| out_valid | output | 1 | One-cycle result pulse |
| out_illegal | output | 1 | Accepted opcode was not a legal shift |
| out_result | output | 32 | New destination register value |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_cycles | output | 8 | Cycle cost of the accepted request |

## Verification
The hardest cases to reach are register counts that overrun the operand width, and left-shift overflow where the sign changes partway through the shift rather than at the end. Uniform random 32-bit counts almost never land in the range 0 to 63 with a useful spread. For that reason the stimulus draws the count register from a narrow band around the byte, word and long widths, and draws operands biased toward runs of equal top bits. Directed cases add count 0, count exactly equal to the width, count one above it, and a request held high across the busy window.

// File: rtl/ashift_pkg.sv
package ashift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned CYC_W  = 8;
  localparam int unsigned OPC_W  = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  typedef struct packed {
    logic       legal;
    logic       left;
    logic       use_reg;
    size_e      size;
    logic [2:0] imm;
  } dec_t;
endpackage

// File: rtl/ashift_decode.sv
module ashift_decode
  import ashift_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  logic group_ok;
  logic form_ok;

  always_comb begin
    group_ok    = (opcode[15:12] == 4'b1110);
    form_ok     = (opcode[4:3] == 2'b00);
    dec.size    = size_e'(opcode[7:6]);
    dec.left    = opcode[8];
    dec.use_reg = opcode[5];
    dec.imm     = opcode[11:9];
    dec.legal   = group_ok && form_ok && (opcode[7:6] != 2'b11);
  end
endmodule

// File: rtl/ashift_count.sv
module ashift_count
  import ashift_pkg::*;
(
  input  dec_t              dec,
  input  logic [DATA_W-1:0] count_reg,
  output logic [CNT_W-1:0]  count,
  output logic [CYC_W-1:0]  cyc
);
  localparam logic [CYC_W-1:0] EXTRA_LONG  = CYC_W'(4);
  localparam logic [CYC_W-1:0] EXTRA_SHORT = CYC_W'(2);

  always_comb begin
    if (dec.use_reg)
      count = count_reg[CNT_W-1:0];
    else if (dec.imm == 3'd0)
      count = CNT_W'(8);
    else
      count = CNT_W'(dec.imm);
    cyc = CYC_W'({count, 1'b0}) +
          ((dec.size == SZ_LONG) ? EXTRA_LONG : EXTRA_SHORT);
  end
endmodule

// File: rtl/ashift_core.sv
module ashift_core
  import ashift_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  size_e             size,
  input  logic              left,
  input  logic [CNT_W-1:0]  count,
  input  logic              x_in,
  output logic [DATA_W-1:0] result,
  output logic              x_out,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              c_out
);
  localparam int unsigned EXT_W = 2 * DATA_W;
  localparam int unsigned LSH_W = 3 * DATA_W;

  logic [DATA_W-1:0] sz_mask;
  logic [DATA_W-1:0] opz;
  logic              sign;
  int unsigned       w;
  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  rsh;
  logic [LSH_W-1:0]  lsh;
  logic [DATA_W-1:0] sized;
  logic [DATA_W-1:0] part;
  logic [DATA_W-1:0] top_bits;
  logic              r_carry;
  logic              l_carry;
  logic              l_ovf;
  logic              zero_cnt;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin sz_mask = DATA_W'(32'h0000_00FF); w = 8;  sign = operand[7];  end
      SZ_WORD: begin sz_mask = DATA_W'(32'h0000_FFFF); w = 16; sign = operand[15]; end
      default: begin sz_mask = '1;                     w = 32; sign = operand[31]; end
    endcase
    opz = operand & sz_mask;
  end

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_part
      assign part[g] = (g < w) && ((g + int'(count)) >= (int'(w) - 1));
    end
  endgenerate

  always_comb begin
    ext = {{DATA_W{sign}}, (sign ? (operand | ~sz_mask) : opz)};
    rsh = ext >> count;
    for (int k = 0; k < int'(EXT_W); k++)
      if (k >= EXT_W - int'(count)) rsh[k] = sign;
    r_carry = ext[CNT_W'(count - CNT_W'(1))];
    lsh = {{(LSH_W-DATA_W){1'b0}}, opz} << count;
    unique case (size)
      SZ_BYTE: l_carry = lsh[8];
      SZ_WORD: l_carry = lsh[16];
      default: l_carry = lsh[32];
    endcase
    top_bits = opz & part;
    if (int'(count) >= int'(w))
      l_ovf = (opz != '0);
    else
      l_ovf = !((top_bits == '0) || (top_bits == part));
  end

  always_comb begin
    zero_cnt = (count == '0);
    sized    = (left ? lsh[DATA_W-1:0] : rsh[DATA_W-1:0]) & sz_mask;
    result   = (operand & ~sz_mask) | sized;
    unique case (size)
      SZ_BYTE: n_out = sized[7];
      SZ_WORD: n_out = sized[15];
      default: n_out = sized[31];
    endcase
    z_out = (sized == '0);
    c_out = zero_cnt ? 1'b0 : (left ? l_carry : r_carry);
    x_out = zero_cnt ? x_in : c_out;
    v_out = left && !zero_cnt && l_ovf;
  end
endmodule

// File: rtl/ashift_seq.sv
module ashift_seq #(
  parameter int unsigned CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] cyc_in,
  output logic             ready,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_e;
  state_e           st_q;
  logic [CYC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      left_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          left_q <= cyc_in;
          st_q   <= (cyc_in == '0) ? S_DONE : S_BUSY;
        end
        S_BUSY: begin
          if (left_q == CYC_W'(1)) st_q <= S_DONE;
          left_q <= left_q - CYC_W'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready = (st_q == S_IDLE);
  assign busy  = (st_q == S_BUSY);
  assign done  = (st_q == S_DONE);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left_q == CYC_W'(1)) |=> done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |-> !ready);
endmodule

// File: rtl/ashift_unit.sv
module ashift_unit
  import ashift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_count_reg,
  input  logic              in_x,
  output logic              busy,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_result,
  output logic              out_x,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_c,
  output logic [CYC_W-1:0]  out_cycles
);
  dec_t              dec;
  logic [CNT_W-1:0]  count;
  logic [CYC_W-1:0]  cyc_raw;
  logic [CYC_W-1:0]  cyc_eff;
  logic [DATA_W-1:0] core_res;
  logic              core_x, core_n, core_z, core_v, core_c;
  logic              accept;

  ashift_decode u_dec (.opcode(in_opcode), .dec(dec));

  ashift_count u_cnt (
    .dec(dec), .count_reg(in_count_reg), .count(count), .cyc(cyc_raw)
  );

  ashift_core u_core (
    .operand(in_dst), .size(dec.size), .left(dec.left), .count(count),
    .x_in(in_x), .result(core_res), .x_out(core_x), .n_out(core_n),
    .z_out(core_z), .v_out(core_v), .c_out(core_c)
  );

  assign accept  = in_valid && in_ready;
  assign cyc_eff = dec.legal ? cyc_raw : '0;

  ashift_seq #(.CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .cyc_in(cyc_eff),
    .ready(in_ready), .busy(busy), .done(out_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_x       <= 1'b0;
      out_n       <= 1'b0;
      out_z       <= 1'b0;
      out_v       <= 1'b0;
      out_c       <= 1'b0;
      out_cycles  <= '0;
    end else if (accept) begin
      out_illegal <= !dec.legal;
      out_cycles  <= cyc_eff;
      if (dec.legal) begin
        out_result <= core_res;
        out_x      <= core_x;
        out_n      <= core_n;
        out_z      <= core_z;
        out_v      <= core_v;
        out_c      <= core_c;
      end else begin
        out_result <= in_dst;
        out_x      <= in_x;
        out_n      <= 1'b0;
        out_z      <= 1'b0;
        out_v      <= 1'b0;
        out_c      <= 1'b0;
      end
    end
  end

  p_illegal_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.legal) |=> (out_valid && out_illegal && !busy));
  p_imm_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && !dec.use_reg) |-> (count != '0 && count <= CNT_W'(8)));
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && dec.size == SZ_BYTE) |-> (core_res[31:8] == in_dst[31:8]));
  p_right_no_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && !dec.left) |-> !core_v);
  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && count == '0) |-> (!core_c && !core_v && core_x == in_x));
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(out_result));
endmodule

// File: tb/ashift_unit_test.sv
`timescale 1ns/1ps
module ashift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_opcode = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_count_reg = '0;
  logic        in_x = 1'b0;
  logic        busy, out_valid, out_illegal;
  logic [31:0] out_result;
  logic        out_x, out_n, out_z, out_v, out_c;
  logic [7:0]  out_cycles;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ashift_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_dst(in_dst), .in_count_reg(in_count_reg),
    .in_x(in_x), .busy(busy), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_result(out_result), .out_x(out_x), .out_n(out_n), .out_z(out_z),
    .out_v(out_v), .out_c(out_c), .out_cycles(out_cycles)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(
    input logic [15:0] op, input logic [31:0] dst, input logic [31:0] creg,
    input logic xin, output logic ill, output logic [31:0] res,
    output logic [4:0] xnzvc, output int cyc, output int cnt);
    int w;
    logic [31:0] mask, val, nv;
    logic c, v;
    ill = (op[15:12] != 4'hE) || (op[4:3] != 2'b00) || (op[7:6] == 2'b11);
    cnt = 0; cyc = 0;
    if (ill) begin
      res = dst; xnzvc = {xin, 4'b0000};
      return;
    end
    w = (op[7:6] == 2'b00) ? 8 : (op[7:6] == 2'b01) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    cnt = op[5] ? int'(creg[5:0]) : ((op[11:9] == 3'd0) ? 8 : int'(op[11:9]));
    cyc = 2 * cnt + ((w == 32) ? 4 : 2);
    val = dst & mask; c = 1'b0; v = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      if (op[8]) begin
        c  = val[w-1];
        nv = (val << 1) & mask;
        if (nv[w-1] != val[w-1]) v = 1'b1;
      end else begin
        c  = val[0];
        nv = (val >> 1) | ({31'b0, val[w-1]} << (w - 1));
      end
      val = nv;
    end
    res = (dst & ~mask) | val;
    xnzvc = {(cnt == 0) ? xin : c, val[w-1], (val == 0), v, c};
  endfunction

  task automatic run(input string tag, input logic [15:0] op,
                     input logic [31:0] dst, input logic [31:0] creg, input logic xin);
    logic ill; logic [31:0] eres; logic [4:0] ef; int ecyc, ecnt;
    int seen; int guard;
    string ftag, vtag;
    model(op, dst, creg, xin, ill, eres, ef, ecyc, ecnt);
    @(negedge clk);
    in_opcode = op; in_dst = dst; in_count_reg = creg; in_x = xin; in_valid = 1'b1;
    @(negedge clk);
    // request stays raised with new data while busy: must be ignored (R11)
    in_opcode = 16'hFFFF; in_dst = ~dst;
    seen = 0; guard = 0;
    while (!out_valid && guard < 300) begin
      if (busy) seen++;
      chk("R11 ready low while busy", {31'b0, in_ready}, 32'd0);
      guard++;
      @(negedge clk);
    end
    if (guard >= 300) begin
      failures++;
      $display("FAIL R10 no completion actual=timeout expected=done");
    end
    in_valid = 1'b0;
    ftag = (ecnt == 0) ? "R9" : "R7";
    vtag = (ecnt == 0) ? "R9" : "R8";
    chk({tag, " R1 illegal"}, {31'b0, out_illegal}, {31'b0, ill});
    chk({tag, " result"}, out_result, eres);
    chk({ftag, " X"}, {31'b0, out_x}, {31'b0, ef[4]});
    chk({ftag, " N"}, {31'b0, out_n}, {31'b0, ef[3]});
    chk({ftag, " Z"}, {31'b0, out_z}, {31'b0, ef[2]});
    chk({vtag, " V"}, {31'b0, out_v}, {31'b0, ef[1]});
    chk({ftag, " C"}, {31'b0, out_c}, {31'b0, ef[0]});
    chk("R10 cycles port", {24'b0, out_cycles}, ecyc);
    chk("R10 busy length", seen, ecyc);
    @(negedge clk);
    chk("R11 idle after done", {29'b0, busy, out_valid, in_ready}, 32'd1);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] ccc, input logic d,
                                     input logic [1:0] zz, input logic i);
    return {4'hE, ccc, d, zz, i, 2'b00, 3'd2};
  endfunction

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {29'b0, busy, out_valid, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run("R2 imm zero means 8", mk(3'd0, 1'b0, 2'b10, 1'b0), 32'h8000_1234, 32'h0, 1'b0);
    run("R2 imm 3 left byte",  mk(3'd3, 1'b1, 2'b00, 1'b0), 32'hAAAA_AA35, 32'h0, 1'b1);
    run("R3 reg mod 64",       mk(3'd1, 1'b0, 2'b01, 1'b1), 32'h1234_8001, 32'hFFFF_FFC5, 1'b0);
    run("R9 zero count",       mk(3'd1, 1'b1, 2'b10, 1'b1), 32'h8000_0000, 32'h0000_0040, 1'b1);
    run("R4 right byte over",  mk(3'd1, 1'b0, 2'b00, 1'b1), 32'h5555_5580, 32'd20, 1'b0);
    run("R4 right long 40",    mk(3'd1, 1'b0, 2'b10, 1'b1), 32'h8000_0001, 32'd40, 1'b0);
    run("R5 left word eq w",   mk(3'd1, 1'b1, 2'b01, 1'b1), 32'h0000_0001, 32'd16, 1'b0);
    run("R5 left word over",   mk(3'd1, 1'b1, 2'b01, 1'b1), 32'hFFFF_FFFF, 32'd17, 1'b1);
    run("R6 byte upper kept",  mk(3'd7, 1'b0, 2'b00, 1'b0), 32'hDEAD_BEF0, 32'h0, 1'b0);
    run("R8 left long ovf",    mk(3'd2, 1'b1, 2'b10, 1'b0), 32'h2000_0000, 32'h0, 1'b0);
    run("R1 size 11",          mk(3'd2, 1'b0, 2'b11, 1'b0), 32'h1357_9BDF, 32'h0, 1'b1);
    run("R1 bad group",        16'h6000, 32'h0000_0042, 32'h0, 1'b0);
    // constrained random
    for (int n = 0; n < 150; n++) begin
      logic [15:0] op; logic [31:0] d, cr; logic [1:0] zz;
      zz = ($urandom % 10 == 0) ? 2'b11 : 2'($urandom % 3);
      op = mk(3'($urandom), 1'($urandom), zz, 1'($urandom));
      op[2:0] = 3'($urandom);
      if ($urandom % 20 == 0) op = 16'($urandom);
      d = $urandom;
      if ($urandom % 2 == 0) d = (d[0] ? 32'hFFFF_FFFF : 32'h0) ^ (32'($urandom % 16) << ($urandom % 32));
      cr = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 40);
      run("R7 random", op, d, cr, 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule